// File: doc/BRIEF.md
# Gated Time-Interval Counter

This block measures the time between a start event and a stop event as a number of reference clock periods. Each counted period stands for 10 ns of a 100 MHz reference. The count is held in two stages. A 5-bit fast prescaler counts the gated ticks. Its carry advances a 7-bit coarse stage. Together they give a 12-bit interval with 4096 channels, about 40 µs of span.

A measurement runs as follows. The control logic clears both stages, and a start strobe then opens the counting window. While the window is open, every clock cycle in which the gate enable is high adds one to the count. The window closes on a stop strobe or when the coarse stage runs past its capacity. A later write request copies the combined count to the output and raises a one-cycle valid strobe. If the measurement overflowed, the write request produces no result. The overflow flag stays visible until the next clear. All event inputs are single-cycle strobes that are synchronous to the counting clock.

Top module: `tof_interval_counter`

## Requirements
- R1: While rst_ni is low, interval_o, overflow_o and valid_o are 0. A cycle with clear_i high zeroes both count stages, clears overflow_o, closes the window and suppresses any write request in that cycle. interval_o keeps its last latched value.
- R2: A start_i strobe that arrives while the window is closed and overflow_o is 0 opens the window. From the next cycle on, each cycle with the window open and gate_en_i high adds one to the count. The start cycle itself adds nothing.
- R3: A write_i strobe in a cycle where overflow_o is 0 makes interval_o equal, after the next edge, to the count held in the write cycle. That count excludes any tick of the write cycle itself. When overflow_o is 1, write_i leaves interval_o unchanged and raises no valid_o.
- R4: The fast stage forms interval_o[4:0] and the coarse stage forms interval_o[11:5]. When the fast stage steps from 31 to 0, the coarse stage advances by one.
- R5: A measurement of up to 4095 ticks completes without overflow. The 4096th tick wraps both stages to 0, sets overflow_o and closes the window.
- R6: A stop_i strobe while the window is open closes it, and the cycle that carries the stop adds no tick. A stop_i strobe while the window is closed is ignored. A start and a stop in the same cycle on a closed window open it.
- R7: A start_i strobe while the window is already open is ignored: counting continues unchanged.
- R8: A cycle with gate_en_i low adds no tick and leaves the window open.
- R9: valid_o is high for exactly one cycle per accepted write request, in the cycle after that request.
- R10: Once set, overflow_o stays 1 until a clear, whatever stop_i, start_i, gate_en_i or write_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, one period per channel |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear before each new event |
| start_i | input | 1 | Start-event strobe |
| stop_i | input | 1 | Stop-event strobe |
| gate_en_i | input | 1 | Tick enable from the control logic |
| write_i | input | 1 | Request to record the combined count |
| interval_o | output | 12 | Latched interval, coarse bits over fast bits |
| overflow_o | output | 1 | Sticky capacity-exceeded flag |
| valid_o | output | 1 | One-cycle strobe for a new interval_o |

## Verification
A write request sampled at edge k updates interval_o and raises valid_o at edge k+1. The monitor compares them at the falling edge that follows. The expected item is pushed into the queue while the request is being driven, so each result is matched to exactly one request, and an extra valid_o finds an empty queue. The tick count is modelled at the same point the design samples its inputs: a start or stop becomes effective at edge k, and the first tick after a start is the edge after it. The overflow flag is checked at the falling edge after the 4096th tick. Absent results are checked at the falling edge after a suppressed or cleared write.

// File: rtl/tic_pkg.sv
package tic_pkg;
   localparam int unsigned FAST_BITS_DEF   = 5;
   localparam int unsigned COARSE_BITS_DEF = 7;

   typedef enum logic {
      WIN_SHUT = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;
endpackage

// File: rtl/tic_fast_stage.sv
module tic_fast_stage #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_o
);
   localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + ONE;
   end

   assign count_o = cnt_q;
   assign carry_o = tick_i && !clr_i && (cnt_q == TOP_VAL);

   // R2: one gated tick advances the prescaler by one
   p_fast_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !clr_i |=> cnt_q == $past(cnt_q) + ONE);
   // R8: without a tick the prescaler holds
   p_fast_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i && !clr_i |=> $stable(cnt_q));
   // R4: a carry leaves the prescaler at zero
   p_fast_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      carry_o |=> cnt_q == '0);
endmodule

// File: rtl/tic_coarse_stage.sv
module tic_coarse_stage #(
   parameter int unsigned WIDTH = 7,
   parameter int unsigned LIMIT = 2 ** WIDTH
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   output logic [WIDTH-1:0] count_o,
   output logic             wrap_o
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] LAST = WIDTH'(LIMIT - 1);

   if (LIMIT < 2 || LIMIT > 2 ** WIDTH) begin : g_bad_limit
      $error("tic_coarse_stage: LIMIT out of range for WIDTH");
   end

   logic [WIDTH-1:0] cnt_q;
   logic             at_last;

   if (LIMIT == 2 ** WIDTH) begin : g_full_range
      assign at_last = &cnt_q;
   end else begin : g_part_range
      assign at_last = (cnt_q == LAST);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (tick_i)  cnt_q <= at_last ? '0 : cnt_q + ONE;
   end

   assign count_o = cnt_q;
   assign wrap_o  = tick_i && !clr_i && at_last;

   // R4: a prescaler carry below the limit advances the coarse stage by one
   p_coarse_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !clr_i && !wrap_o |=> cnt_q == $past(cnt_q) + ONE);
   // R5: running past capacity leaves the coarse stage at zero
   p_coarse_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/tic_window_ctrl.sv
module tic_window_ctrl
   import tic_pkg::*;
#(
   parameter int unsigned COUNT_W = 12
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clear_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               gate_en_i,
   input  logic               write_i,
   input  logic               wrap_i,
   input  logic [COUNT_W-1:0] count_i,
   output logic               tick_o,
   output logic [COUNT_W-1:0] interval_o,
   output logic               overflow_o,
   output logic               valid_o
);
   win_state_e         win_q;
   logic               ovf_q;
   logic               valid_q;
   logic [COUNT_W-1:0] result_q;
   logic               start_ok;
   logic               accept_wr;

   assign start_ok  = (win_q == WIN_SHUT) && start_i && !ovf_q;
   assign accept_wr = write_i && !ovf_q;
   assign tick_o    = (win_q == WIN_OPEN) && gate_en_i && !stop_i && !clear_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_q    <= WIN_SHUT;
         ovf_q    <= 1'b0;
         valid_q  <= 1'b0;
         result_q <= '0;
      end else if (clear_i) begin
         win_q    <= WIN_SHUT;
         ovf_q    <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= accept_wr;
         if (accept_wr) result_q <= count_i;
         if (wrap_i) begin
            ovf_q <= 1'b1;
            win_q <= WIN_SHUT;
         end else if ((win_q == WIN_OPEN) && stop_i) begin
            win_q <= WIN_SHUT;
         end else if (start_ok) begin
            win_q <= WIN_OPEN;
         end
      end
   end

   assign interval_o = result_q;
   assign overflow_o = ovf_q;
   assign valid_o    = valid_q;

   // R1: clear drops overflow, valid and the window
   p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> !ovf_q && !valid_q && win_q == WIN_SHUT);
   // R3: an overflowed measurement yields no result
   p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      write_i && ovf_q && !clear_i |=> !valid_q && $stable(result_q));
   // R5: running past capacity flags overflow and shuts the window
   p_wrap_closes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i && !clear_i |=> ovf_q && win_q == WIN_SHUT);
   // R6: stop shuts an open window
   p_stop_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_q == WIN_OPEN && stop_i && !clear_i |=> win_q == WIN_SHUT);
   // R7: start has no effect on an open window
   p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_q == WIN_OPEN && start_i && !stop_i && !wrap_i && !clear_i
      |=> win_q == WIN_OPEN);
   // R9: no valid strobe without a request
   p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !write_i |=> !valid_q);
   // R10: overflow is sticky until clear
   p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_q && !clear_i |=> ovf_q);
endmodule

// File: rtl/tof_interval_counter.sv
module tof_interval_counter
   import tic_pkg::*;
#(
   parameter int unsigned FAST_W   = FAST_BITS_DEF,
   parameter int unsigned COARSE_W = COARSE_BITS_DEF
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       clear_i,
   input  logic                       start_i,
   input  logic                       stop_i,
   input  logic                       gate_en_i,
   input  logic                       write_i,
   output logic [FAST_W+COARSE_W-1:0] interval_o,
   output logic                       overflow_o,
   output logic                       valid_o
);
   localparam int unsigned TOTAL_W = FAST_W + COARSE_W;

   if (FAST_W < 1 || COARSE_W < 1 || TOTAL_W > 30) begin : g_bad_widths
      $error("tof_interval_counter: stage widths out of range");
   end

   logic                tick;
   logic                fast_carry;
   logic                coarse_wrap;
   logic [FAST_W-1:0]   fast_cnt;
   logic [COARSE_W-1:0] coarse_cnt;

   tic_fast_stage #(.WIDTH(FAST_W)) u_fast (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clear_i),
      .tick_i  (tick),
      .count_o (fast_cnt),
      .carry_o (fast_carry)
   );

   tic_coarse_stage #(.WIDTH(COARSE_W), .LIMIT(2 ** COARSE_W)) u_coarse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clear_i),
      .tick_i  (fast_carry),
      .count_o (coarse_cnt),
      .wrap_o  (coarse_wrap)
   );

   tic_window_ctrl #(.COUNT_W(TOTAL_W)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_i),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .gate_en_i  (gate_en_i),
      .write_i    (write_i),
      .wrap_i     (coarse_wrap),
      .count_i    ({coarse_cnt, fast_cnt}),
      .tick_o     (tick),
      .interval_o (interval_o),
      .overflow_o (overflow_o),
      .valid_o    (valid_o)
   );
endmodule

// File: tb/tof_interval_counter_tb_top.sv
`timescale 1ns/1ps
module tof_interval_counter_tb_top;
   localparam int MAXV     = 4095;
   localparam int WD_LIMIT = 100000;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        clear_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
   logic        gate_en_i = 1'b0, write_i = 1'b0;
   logic [11:0] interval_o;
   logic        overflow_o, valid_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // reference state, built from the requirements
   bit    m_open = 1'b0;
   bit    m_ovf  = 1'b0;
   int    m_cnt  = 0;
   int    exp_q[$];
   string cur_req = "R3";

   always #2.5 clk_i = ~clk_i;

   tof_interval_counter dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear_i),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .gate_en_i  (gate_en_i),
      .write_i    (write_i),
      .interval_o (interval_o),
      .overflow_o (overflow_o),
      .valid_o    (valid_o)
   );

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // monitor: every valid strobe is matched against the queue
   always @(negedge clk_i) begin
      if (rst_ni && valid_o) begin
         if (exp_q.size() == 0) begin
            check(cur_req, 1, 0);
         end else begin
            check(cur_req, int'(interval_o), exp_q.pop_front());
         end
      end
   end

   // driver: one cycle of stimulus, reference updated for the coming edge
   task automatic step(input bit st, input bit sp, input bit g,
                       input bit wr, input bit cl);
      start_i = st; stop_i = sp; gate_en_i = g; write_i = wr; clear_i = cl;
      if (cl) begin
         m_open = 0; m_cnt = 0; m_ovf = 0;
      end else begin
         if (wr && !m_ovf) exp_q.push_back(m_cnt);
         if (m_open && g && !sp) begin
            if (m_cnt == MAXV) begin
               m_cnt = 0; m_ovf = 1; m_open = 0;
            end else begin
               m_cnt++;
            end
         end else if (m_open && sp) begin
            m_open = 0;
         end else if (!m_open && st && !m_ovf) begin
            m_open = 1;
         end
      end
      @(negedge clk_i);
      start_i = 0; stop_i = 0; gate_en_i = 0; write_i = 0; clear_i = 0;
   endtask

   task automatic run(input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         step(0, 0, (mode == 0) ? 1'b1 : (i % 3 != 0), 0, 0);
      end
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk_i);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1: reset state
      check("R1", int'(interval_o), 0);
      check("R1", int'(overflow_o), 0);
      check("R1", int'(valid_o), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R2: plain measurement of 37 ticks
      cur_req = "R2";
      step(0, 0, 0, 0, 1);
      step(1, 0, 1, 0, 0);
      run(37, 0);
      step(0, 1, 1, 0, 0);
      step(0, 0, 0, 1, 0);
      // R9: strobe lasts one cycle
      step(0, 0, 0, 0, 0);
      check("R9", int'(valid_o), 0);
      check("R2", int'(interval_o), 37);

      // R8: gate enable pattern with low cycles
      cur_req = "R8";
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(50, 1);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 1, 0);

      // R7: second start inside an open window
      cur_req = "R7";
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(10, 0);
      step(1, 0, 1, 0, 0);
      run(10, 0);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R7", int'(interval_o), 21);

      // R6: stray stop on a closed window, then start and stop together
      cur_req = "R6";
      step(0, 0, 0, 0, 1);
      step(0, 1, 1, 0, 0);
      step(1, 1, 1, 0, 0);
      run(5, 0);
      step(0, 1, 1, 0, 0);
      run(3, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R6", int'(interval_o), 5);

      // R3: snapshot while counting continues
      cur_req = "R3";
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(10, 0);
      step(0, 0, 1, 1, 0);
      run(4, 0);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R3", int'(interval_o), 15);

      // R4: field split at 33 ticks
      cur_req = "R4";
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(33, 0);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R4", int'(interval_o[4:0]), 1);
      check("R4", int'(interval_o[11:5]), 1);

      // R5: largest value without overflow
      cur_req = "R5";
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(4095, 0);
      step(0, 1, 0, 0, 0);
      check("R5", int'(overflow_o), 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R5", int'(interval_o), 4095);

      // R5: 4096 ticks overflow
      step(0, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      run(4096, 0);
      check("R5", int'(overflow_o), 1);
      // R3: write suppressed, interval held
      cur_req = "R3";
      step(0, 0, 0, 1, 0);
      check("R3", int'(valid_o), 0);
      check("R3", int'(interval_o), 4095);
      // R10: flag survives other strobes
      step(0, 1, 1, 0, 0);
      step(1, 0, 1, 0, 0);
      run(5, 0);
      step(0, 0, 0, 1, 0);
      check("R10", int'(overflow_o), 1);
      check("R10", int'(valid_o), 0);

      // R1: clear drops the flag and zeroes both stages
      cur_req = "R1";
      step(0, 0, 0, 1, 1);
      check("R1", int'(overflow_o), 0);
      check("R1", int'(valid_o), 0);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check("R1", int'(interval_o), 0);

      repeat (3) @(negedge clk_i);
      while (exp_q.size() > 0) begin
         check("R3", -1, exp_q.pop_front());
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule